// File: doc/BRIEF.md
# XGMII frame and gap monitor

This block watches a 64-bit XGMII receive or transmit bus without driving it. Every clock it takes the eight control bits and 64 data bits and walks the eight byte lanes in order, lane 0 first. It follows each frame from its start character to its terminate character. It reports the packet count, the byte length of the last finished frame and the inter-frame gap measured at each new start.

Protocol faults raise sticky flags, one per kind of fault. A code register keeps the first fault seen since the last clear. The minimum gap is a parameter. An optional deficit-idle allowance lets single gaps fall short of that minimum, as long as the running shortfall stays at 3 bytes or less. The monitor is meant to sit beside a MAC or PHY in simulation-capable hardware, or on a debug tap, to certify line timing and framing.

Top module: `xgm_monitor`

## Requirements
- R1: After reset, pkt_count_o, frame_len_o, frame_done_o, gap_o, deficit_o, in_frame_o, err_flags_o and err_code_o are all zero. The internal gap count starts at 15, so a frame that begins on the very first word raises no gap fault.
- R2: Lane i is control bit i with data bits 8i+7:8i, and the lanes are handled in the order 0 to 7. With its control bit at 1, 0xFB is a start, 0xFD is a terminate and 0x07 is an idle. A byte with its control bit at 0 is data. in_frame_o is 1 while a frame is open at the end of a word.
- R3: The frame length counts the start byte plus every data byte before the terminate. On the edge that takes a terminate word, frame_len_o takes that length, frame_done_o is 1 for one cycle and pkt_count_o increases by one per frame. Two frames may end in one word.
- R4: A start in any lane other than 0 or 4 sets err_flags_o bit 0, and the frame still opens.
- R5: A start while a frame is open sets bit 1. The open frame is dropped without being counted, and a new frame opens with length 1.
- R6: An idle while a frame is open sets bit 2. The frame stays open and the idle adds nothing to its length.
- R7: A byte whose control bit is 1 and whose value is none of 0xFB, 0xFD or 0x07 sets bit 3.
- R8: The gap is the terminate byte plus the idles that follow it, up to the next start. gap_o takes that count when the start arrives. Data bytes outside a frame are ignored and add nothing to the gap.
- R9: With the deficit allowance off, a gap below MIN_GAP sets bit 4.
- R10: With the deficit allowance on, a short gap adds MIN_GAP minus the gap to deficit_o. If the sum would exceed 3, bit 4 is set and the deficit returns to 0. A gap above MIN_GAP lowers the deficit by the excess, but never below 0.
- R11: A terminate outside a frame is ignored until one frame has completed. After that it sets bit 5.
- R12: Flags stay set until clr_i, which zeroes flags and code on the next edge and takes priority over new faults. err_code_o holds the first fault since the last clear, as its bit index plus 1 (1 to 6). When several faults arrive in one word, the lowest bit index is the one recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of the fault flags and the code |
| xgmii_ctl_i | input | 8 | Control bit per lane |
| xgmii_data_i | input | 64 | Data byte per lane |
| pkt_count_o | output | 16 | Number of completed frames (wraps) |
| frame_len_o | output | 16 | Byte length of the last completed frame |
| frame_done_o | output | 1 | One-cycle pulse when at least one frame ended |
| gap_o | output | 8 | Gap measured at the latest accepted start |
| deficit_o | output | 2 | Current deficit-idle shortfall |
| in_frame_o | output | 1 | A frame is open |
| err_flags_o | output | 6 | Sticky fault flags, bits 0 to 5 as in R4 to R11 |
| err_code_o | output | 3 | First fault since clear, bit index plus 1 |

## Verification
The bench checks a frame that starts on the first word after reset, to show the preset gap count. It checks two frames packed into one word, to tell per-lane ordering apart from per-word handling. It checks starts in a wrong lane, starts and idles inside a frame, and stray terminates before and after the first frame. Each of these shows that one fault kind is separate from the others. A run of evenly spaced 11-byte gaps walks the deficit up to 3 and then past it, while a second instance with the allowance off and a minimum of 5 sees the same gaps as legal. Long random streams with injected bad bytes, early terminates and misplaced starts are then compared word by word with a bench model of the rules.

// File: rtl/xgm_pkg.sv
package xgm_pkg;

    // Control character values decoded on each byte lane (R2)
    localparam logic [7:0] CH_START = 8'hFB;
    localparam logic [7:0] CH_TERM  = 8'hFD;
    localparam logic [7:0] CH_IDLE  = 8'h07;

    typedef enum logic [2:0] {
        LK_DATA,
        LK_START,
        LK_TERM,
        LK_IDLE,
        LK_BAD
    } lane_kind_e;

    // Fault flag bit positions; the code register reports index + 1
    localparam int ERR_LANE     = 0;
    localparam int ERR_RESTART  = 1;
    localparam int ERR_IDLE_IN  = 2;
    localparam int ERR_BADCTL   = 3;
    localparam int ERR_GAP      = 4;
    localparam int ERR_STRAY    = 5;
    localparam int ERR_N        = 6;
    localparam int CODE_W       = 3;

endpackage

// File: rtl/xgm_lane_dec.sv
module xgm_lane_dec
    import xgm_pkg::*;
(
    input  logic       ctl_i,
    input  logic [7:0] byte_i,
    output lane_kind_e kind_o
);

    always_comb begin
        if (!ctl_i) begin
            kind_o = LK_DATA;
        end else begin
            unique case (byte_i)
                CH_START: kind_o = LK_START;
                CH_TERM:  kind_o = LK_TERM;
                CH_IDLE:  kind_o = LK_IDLE;
                default:  kind_o = LK_BAD;
            endcase
        end
    end

endmodule

// File: rtl/xgm_err_reg.sv
module xgm_err_reg #(
    parameter int N  = 6,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [N-1:0]  ev_i,
    output logic [N-1:0]  flags_o,
    output logic [CW-1:0] code_o
);

    typedef struct packed {
        logic [N-1:0]  flags;
        logic [CW-1:0] code;
    } err_state_t;

    err_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else begin
            if ((st_q.code == '0) && (ev_i != '0)) begin
                for (int j = N - 1; j >= 0; j--) begin
                    if (ev_i[j]) st_d.code = CW'(j + 1);
                end
            end
            st_d.flags = st_q.flags | ev_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign code_o  = st_q.code;

    // R12
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

    // R12
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (flags_o == '0 && code_o == '0));

    // R12
    code_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((code_o != '0) == (flags_o != '0)));

    // R12
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o != '0 && !clr_i) |=> $stable(code_o));

endmodule

// File: rtl/xgm_monitor.sv
module xgm_monitor
    import xgm_pkg::*;
#(
    parameter int   LANES    = 8,
    parameter int   MIN_GAP  = 12,
    parameter bit   DIC_EN   = 1'b1,
    parameter int   CNT_W    = 16,
    parameter int   LEN_W    = 16,
    parameter int   GAP_W    = 8,
    parameter int   GAP_INIT = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic [LANES-1:0]     xgmii_ctl_i,
    input  logic [LANES*8-1:0]   xgmii_data_i,
    output logic [CNT_W-1:0]     pkt_count_o,
    output logic [LEN_W-1:0]     frame_len_o,
    output logic                 frame_done_o,
    output logic [GAP_W-1:0]     gap_o,
    output logic [1:0]           deficit_o,
    output logic                 in_frame_o,
    output logic [ERR_N-1:0]     err_flags_o,
    output logic [CODE_W-1:0]    err_code_o
);

    localparam int DEF_MAX  = 3;
    localparam int HALF     = 4;

    typedef struct packed {
        logic             in_frame;
        logic             seen_end;
        logic [LEN_W-1:0] len;
        logic [GAP_W-1:0] gap;
        logic [GAP_W-1:0] gap_last;
        logic [1:0]       deficit;
        logic [CNT_W-1:0] cnt;
        logic [LEN_W-1:0] last_len;
        logic             done;
    } mon_state_t;

    mon_state_t       s_d, s_q;
    lane_kind_e       kind [LANES];
    logic [ERR_N-1:0] ev_d;

    // Per-lane control decode (R2)
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        xgm_lane_dec u_dec (
            .ctl_i  (xgmii_ctl_i[g]),
            .byte_i (xgmii_data_i[8*g +: 8]),
            .kind_o (kind[g])
        );
    end

    // Lanes are applied in order, lane 0 first, within one cycle
    always_comb begin
        int nd;
        s_d      = s_q;
        s_d.done = 1'b0;
        ev_d     = '0;
        nd       = 0;
        for (int i = 0; i < LANES; i++) begin
            unique case (kind[i])
                LK_DATA: begin
                    // R8: data outside a frame is ignored
                    if (s_d.in_frame && (s_d.len != '1)) s_d.len = s_d.len + 1'b1;
                end
                LK_START: begin
                    // R4: start only in lane 0 of a 32-bit half
                    if ((i % HALF) != 0) ev_d[ERR_LANE] = 1'b1;
                    if (s_d.in_frame) begin
                        // R5: open frame dropped, a new one begins
                        ev_d[ERR_RESTART] = 1'b1;
                    end else begin
                        s_d.gap_last = s_d.gap;
                        if (DIC_EN) begin
                            // R10
                            if (int'(s_d.gap) < MIN_GAP) begin
                                nd = int'(s_d.deficit) + (MIN_GAP - int'(s_d.gap));
                                if (nd > DEF_MAX) begin
                                    ev_d[ERR_GAP] = 1'b1;
                                    s_d.deficit   = '0;
                                end else begin
                                    s_d.deficit = 2'(nd);
                                end
                            end else begin
                                nd = int'(s_d.deficit) - (int'(s_d.gap) - MIN_GAP);
                                s_d.deficit = (nd < 0) ? 2'd0 : 2'(nd);
                            end
                        end else if (int'(s_d.gap) < MIN_GAP) begin
                            // R9
                            ev_d[ERR_GAP] = 1'b1;
                        end
                        s_d.gap = '0;
                    end
                    s_d.in_frame = 1'b1;
                    s_d.len      = LEN_W'(1);
                end
                LK_TERM: begin
                    if (s_d.in_frame) begin
                        // R3
                        s_d.cnt      = s_d.cnt + 1'b1;
                        s_d.last_len = s_d.len;
                        s_d.done     = 1'b1;
                        s_d.seen_end = 1'b1;
                        s_d.in_frame = 1'b0;
                        s_d.gap      = GAP_W'(1);
                    end else if (s_d.seen_end) begin
                        // R11
                        ev_d[ERR_STRAY] = 1'b1;
                    end
                end
                LK_IDLE: begin
                    if (s_d.in_frame) begin
                        // R6
                        ev_d[ERR_IDLE_IN] = 1'b1;
                    end else if (s_d.gap != '1) begin
                        s_d.gap = s_d.gap + 1'b1;
                    end
                end
                default: begin
                    // R7
                    ev_d[ERR_BADCTL] = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.gap <= GAP_W'(GAP_INIT);
        end else begin
            s_q     <= s_d;
        end
    end

    xgm_err_reg #(
        .N  (ERR_N),
        .CW (CODE_W)
    ) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .ev_i    (ev_d),
        .flags_o (err_flags_o),
        .code_o  (err_code_o)
    );

    assign pkt_count_o  = s_q.cnt;
    assign frame_len_o  = s_q.last_len;
    assign frame_done_o = s_q.done;
    assign gap_o        = s_q.gap_last;
    assign deficit_o    = s_q.deficit;
    assign in_frame_o   = s_q.in_frame;

    // R3
    done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> (frame_len_o != '0));

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done_o |-> (pkt_count_o == $past(pkt_count_o)));

endmodule

// File: tb/tb_xgm_monitor.sv
module tb_xgm_monitor;

    localparam logic [7:0]  FB = 8'hFB;
    localparam logic [7:0]  FD = 8'hFD;
    localparam logic [7:0]  ID = 8'h07;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [7:0]  xg_ctl = 8'hFF;
    logic [63:0] xg_dat = {8{8'h07}};

    logic [15:0] o_cnt  [2];
    logic [15:0] o_len  [2];
    logic        o_done [2];
    logic [7:0]  o_gap  [2];
    logic [1:0]  o_def  [2];
    logic        o_in   [2];
    logic [5:0]  o_fl   [2];
    logic [2:0]  o_code [2];

    always #4 clk = ~clk;

    xgm_monitor dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr),
        .xgmii_ctl_i(xg_ctl), .xgmii_data_i(xg_dat),
        .pkt_count_o(o_cnt[0]), .frame_len_o(o_len[0]), .frame_done_o(o_done[0]),
        .gap_o(o_gap[0]), .deficit_o(o_def[0]), .in_frame_o(o_in[0]),
        .err_flags_o(o_fl[0]), .err_code_o(o_code[0])
    );

    xgm_monitor #(.MIN_GAP(5), .DIC_EN(1'b0)) dut_nodic (
        .clk(clk), .rst_n(rst_n), .clr_i(clr),
        .xgmii_ctl_i(xg_ctl), .xgmii_data_i(xg_dat),
        .pkt_count_o(o_cnt[1]), .frame_len_o(o_len[1]), .frame_done_o(o_done[1]),
        .gap_o(o_gap[1]), .deficit_o(o_def[1]), .in_frame_o(o_in[1]),
        .err_flags_o(o_fl[1]), .err_code_o(o_code[1])
    );

    int n_chk = 0;
    int n_err = 0;

    // Bench model of the rules, one state set per instance
    int  m_min [2] = '{12, 5};
    bit  m_dic [2] = '{1'b1, 1'b0};
    bit  m_in [2], m_seen [2], m_done [2];
    int  m_len [2], m_gap [2], m_gapl [2], m_def [2], m_cnt [2], m_llen [2], m_code [2];
    bit [5:0] m_fl [2];

    logic       bq_c [$];
    logic [7:0] bq_d [$];

    string ftag [6] = '{"R4", "R5", "R6", "R7", "R9/R10", "R11"};

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_in[k] = 0; m_seen[k] = 0; m_done[k] = 0; m_len[k] = 0; m_gap[k] = 15;
            m_gapl[k] = 0; m_def[k] = 0; m_cnt[k] = 0; m_llen[k] = 0; m_fl[k] = '0; m_code[k] = 0;
        end
    endtask

    task automatic model_step(input int k, input logic [7:0] c, input logic [63:0] d, input bit cl);
        bit [5:0] ev = '0;
        m_done[k] = 0;
        for (int i = 0; i < 8; i++) begin
            logic [7:0] b = d[8*i +: 8];
            if (!c[i]) begin
                if (m_in[k] && m_len[k] < 65535) m_len[k]++;
            end else if (b == FB) begin
                if (i % 4 != 0) ev[0] = 1;
                if (m_in[k]) ev[1] = 1;
                else begin
                    m_gapl[k] = m_gap[k];
                    if (m_dic[k]) begin
                        if (m_gap[k] < m_min[k]) begin
                            m_def[k] += m_min[k] - m_gap[k];
                            if (m_def[k] > 3) begin ev[4] = 1; m_def[k] = 0; end
                        end else begin
                            m_def[k] -= m_gap[k] - m_min[k];
                            if (m_def[k] < 0) m_def[k] = 0;
                        end
                    end else if (m_gap[k] < m_min[k]) ev[4] = 1;
                    m_gap[k] = 0;
                end
                m_in[k] = 1; m_len[k] = 1;
            end else if (b == FD) begin
                if (m_in[k]) begin
                    m_cnt[k] = (m_cnt[k] + 1) % 65536; m_llen[k] = m_len[k]; m_done[k] = 1;
                    m_seen[k] = 1; m_in[k] = 0; m_gap[k] = 1;
                end else if (m_seen[k]) ev[5] = 1;
            end else if (b == ID) begin
                if (m_in[k]) ev[2] = 1;
                else if (m_gap[k] < 255) m_gap[k]++;
            end else ev[3] = 1;
        end
        if (cl) begin
            m_fl[k] = '0; m_code[k] = 0;
        end else begin
            if (m_code[k] == 0 && ev != 0) begin
                for (int j = 5; j >= 0; j--) if (ev[j]) m_code[k] = j + 1;
            end
            m_fl[k] |= ev;
        end
    endtask

    task automatic check_all(input int k);
        chk("R3", "pkt_count", o_cnt[k], m_cnt[k]);
        chk("R3", "frame_len", o_len[k], m_llen[k]);
        chk("R3", "frame_done", o_done[k], m_done[k]);
        chk("R8", "gap", o_gap[k], m_gapl[k]);
        chk("R10", "deficit", o_def[k], m_def[k]);
        chk("R2", "in_frame", o_in[k], m_in[k]);
        for (int b = 0; b < 6; b++) chk(ftag[b], "flag bit", o_fl[k][b], m_fl[k][b]);
        chk("R12", "err_code", o_code[k], m_code[k]);
    endtask

    task automatic send(input logic [7:0] c, input logic [63:0] d, input bit cl);
        xg_ctl = c; xg_dat = d; clr = cl;
        @(posedge clk);
        model_step(0, c, d, cl);
        model_step(1, c, d, cl);
        @(negedge clk);
        check_all(0);
        check_all(1);
        clr = 1'b0;
    endtask

    task automatic push(input logic c, input logic [7:0] b);
        bq_c.push_back(c); bq_d.push_back(b);
    endtask

    task automatic idles(input int n);
        for (int j = 0; j < n; j++) push(1'b1, ID);
    endtask

    task automatic frame(input int n);
        push(1'b1, FB);
        for (int j = 1; j < n; j++) push(1'b0, 8'($urandom));
        push(1'b1, FD);
    endtask

    task automatic drain();
        while (bq_c.size() >= 8) begin
            logic [7:0]  c;
            logic [63:0] d;
            for (int i = 0; i < 8; i++) begin
                c[i] = bq_c.pop_front();
                d[8*i +: 8] = bq_d.pop_front();
            end
            send(c, d, 1'b0);
        end
    endtask

    task automatic flush();
        while (bq_c.size() % 8 != 0) push(1'b1, ID);
        drain();
    endtask

    task automatic do_clear();
        send(8'hFF, {8{ID}}, 1'b1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; clr = 1'b0; xg_ctl = 8'hFF; xg_dat = {8{ID}};
        repeat (3) @(negedge clk);
        model_reset();
        for (int k = 0; k < 2; k++) begin
            chk("R1", "reset pkt_count", o_cnt[k], 0);
            chk("R1", "reset frame_len", o_len[k], 0);
            chk("R1", "reset done", o_done[k], 0);
            chk("R1", "reset gap", o_gap[k], 0);
            chk("R1", "reset deficit", o_def[k], 0);
            chk("R1", "reset in_frame", o_in[k], 0);
            chk("R1", "reset flags", o_fl[k], 0);
            chk("R1", "reset code", o_code[k], 0);
        end
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'h1f2e3d4c));
        @(negedge clk);
        do_reset();

        // R1: frame on the first word after reset is legal
        frame(20); flush();
        for (int k = 0; k < 2; k++) begin
            chk("R1", "immediate frame flags", o_fl[k], 0);
            chk("R3", "len 20", o_len[k], 20);
            chk("R3", "count 1", o_cnt[k], 1);
        end

        // R3/R9/R10: two frames ending in one word, gap of 2
        idles(16); flush();
        base = o_cnt[0];
        push(1, FB); push(0, 8'h11); push(1, FD); push(1, ID);
        push(1, FB); push(0, 8'h22); push(0, 8'h33); push(1, FD);
        flush();
        chk("R3", "two per word", o_cnt[0], base + 2);
        for (int k = 0; k < 2; k++) begin
            chk("R3", "last len 3", o_len[k], 3);
            chk("R9/R10", "short gap flag", o_fl[k][4], 1);
            chk("R12", "code gap", o_code[k], 5);
        end
        do_clear();
        chk("R12", "cleared flags", o_fl[0], 0);
        chk("R12", "cleared code", o_code[0], 0);

        // R4: start in lane 2
        idles(18); frame(5); flush();
        for (int k = 0; k < 2; k++) begin
            chk("R4", "lane flag", o_fl[k], 6'b000001);
            chk("R4", "code", o_code[k], 1);
            chk("R4", "frame still opens", o_len[k], 5);
        end
        do_clear();

        // R5: start inside a frame (second start in lane 4)
        idles(16);
        push(1, FB); push(0, 8'h01); push(0, 8'h02); push(0, 8'h03);
        push(1, FB); push(0, 8'h04); push(1, FD);
        flush();
        for (int k = 0; k < 2; k++) begin
            chk("R5", "restart flag", o_fl[k], 6'b000010);
            chk("R5", "code", o_code[k], 2);
            chk("R5", "new frame len", o_len[k], 2);
        end
        do_clear();

        // R6: idle inside a frame
        idles(16);
        push(1, FB); push(0, 8'h05); push(1, ID); push(0, 8'h06); push(1, FD);
        flush();
        for (int k = 0; k < 2; k++) begin
            chk("R6", "idle flag", o_fl[k], 6'b000100);
            chk("R6", "len excl idle", o_len[k], 3);
        end
        do_clear();

        // R8 and R7: data outside frame ignored, then bad control byte
        idles(16); frame(4); idles(5); push(0, 8'hAA); idles(5);
        frame(3); push(1, 8'h9C); flush();
        for (int k = 0; k < 2; k++) begin
            chk("R8", "gap 11", o_gap[k], 11);
            chk("R7", "bad ctl flag", o_fl[k], 6'b001000);
            chk("R7", "code", o_code[k], 4);
        end
        chk("R10", "deficit 1", o_def[0], 1);
        do_clear();

        // R10: deficit climbs to 3, then one more short gap faults
        idles(16);
        for (int r = 0; r < 4; r++) begin frame(9); idles(10); end
        flush();
        chk("R10", "deficit 3", o_def[0], 3);
        chk("R10", "no fault yet", o_fl[0], 0);
        frame(9); flush();
        chk("R10", "deficit fault", o_fl[0][4], 1);
        chk("R10", "deficit back to 0", o_def[0], 0);
        chk("R9", "min 5 accepts 11", o_fl[1], 0);
        do_clear();

        // R10: a long gap lowers the deficit by its excess
        idles(16);
        frame(9); idles(10); frame(9); idles(10); frame(11); idles(12); frame(4);
        flush();
        chk("R10", "deficit reduced", o_def[0], 1);
        chk("R8", "gap 13", o_gap[0], 13);
        do_clear();

        // R11: stray terminate ignored before first frame, flagged after
        do_reset();
        push(1, FD); idles(7); flush();
        chk("R11", "early stray ignored", o_fl[0], 0);
        frame(6); flush();
        push(1, ID); push(1, ID); push(1, FD); flush();
        for (int k = 0; k < 2; k++) begin
            chk("R11", "stray flag", o_fl[k], 6'b100000);
            chk("R11", "code", o_code[k], 6);
            chk("R11", "count", o_cnt[k], 1);
        end
        do_clear();

        // Random traffic against the model
        for (int f = 0; f < 250; f++) begin
            int ln = $urandom_range(1, 40);
            int gp = $urandom_range(1, 20);
            while (bq_c.size() % 4 != 0) push(1, ID);
            if ($urandom_range(0, 19) == 0) push(1, ID);
            push(1, FB);
            for (int j = 1; j < ln; j++) begin
                int r = $urandom_range(0, 31);
                if (r == 0)      push(1, 8'h9C);
                else if (r == 1) push(1, ID);
                else             push(0, 8'($urandom));
            end
            push(1, FD);
            idles(gp - 1);
            if ($urandom_range(0, 15) == 0) push(1, FD);
            drain();
            if (f % 12 == 11) begin flush(); do_clear(); end
        end
        flush();

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule